// File: doc/BRIEF.md
# Rectangle-Chain Lookup-Table Refill Engine

This block fills a two-dimensional page-translation lookup table from memory without processor involvement. Software places a chain of small descriptors in memory. Each descriptor names a rectangle of table slots, a target table, the address of a block of 32-bit page addresses, and the address of the next descriptor. Software then writes the address of the first descriptor into the engine's descriptor register. The engine fetches each descriptor, streams one data word per slot, and writes the words into the table with x varying fastest and then y. When the chain ends it raises a completion bit in its own byte of a shared interrupt status word.

Memory reads use a single-outstanding request/response port: the engine pulses a request with a word address and waits for one response. The table is written through a plain write port that carries the table select, the slot index y*LUT_W+x and the data. Faults are sticky: a misaligned pointer or an inverted rectangle stops the chain, sets an error flag and raises an error interrupt bit. Writing zero to the descriptor register abandons whatever chain is in progress.

Top module: `lut_refill_engine`

## Requirements
- R1: After reset the status register (address 1) reads 1 (READY bit 0 set, ERR bit 1 clear), the interrupt status register (address 2) reads 0, irq is low, and no memory request or table write is made.
- R2: A nonzero, 16-byte-aligned write to the descriptor register (address 0) while READY is set starts a chain: READY drops and the engine reads the four header words at offsets 0, 4, 8 and 12 from that address. Word 0 packs x0 in bits 7:0, x1 in 15:8, y0 in 23:16 and y1 in 31:24; word 1 holds the start flag in bit 0 and the table select in bits 7:4; word 2 is the data pointer; word 3 is the next-descriptor pointer.
- R3: For a descriptor with its start flag set, the engine makes exactly (x1-x0+1)*(y1-y0+1) table writes, taking data words from consecutive addresses upward from the data pointer, in order x0..x1 within each row and rows y0..y1, at index y*LUT_W+x, with the descriptor's table select.
- R4: A nonzero next pointer makes the engine continue with that descriptor; a next pointer of 0 ends the chain, sets bit 8*ENG of the interrupt status and returns READY high; the descriptor register then reads the address of the last descriptor processed.
- R5: A descriptor whose start flag is clear causes no table writes, and the chain continues with its next pointer.
- R6: A start address, data pointer or nonzero next pointer with any of bits 3:0 set sets ERR, sets bit 8*ENG+1 of the interrupt status, produces no table write from that descriptor and leaves the engine idle; the next accepted start clears ERR.
- R7: A rectangle with x1 < x0 or y1 < y0 is treated as a fault exactly as in R6.
- R8: Writing 0 to the descriptor register stops the chain at once: no further memory request or table write is made and no completion bit is set; READY returns once any outstanding read response has come back.
- R9: A nonzero write to the descriptor register while READY is clear is ignored and does not alter the running chain.
- R10: Writing ones to the interrupt status register clears those bits; irq is high exactly when some status bit is set; bits outside this engine's byte always read 0.
- R11: At most one memory read is outstanding: a request is never issued in the cycle after another request, and every requested address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 descriptor, 1 status, 2 interrupt status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| lut_we | output | 1 | Table write strobe |
| lut_sel | output | 4 | Target table select |
| lut_idx | output | IDXW | Slot index y*LUT_W+x |
| lut_data | output | 32 | Page address written into the slot |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
The in-module properties watch, on every cycle, that memory reads never overlap and stay word aligned, that every table write falls inside the current rectangle, that a cancel silences both memory and table ports on the following cycle, that READY only falls because of an accepted start, and that a raised fault always shows in the interrupt status. Whether the right words land at the right slots in the right order, whether chains link and terminate properly, how a clear start flag is skipped, and what a cancel or an ignored restart leaves behind can only be shown by the bench's scenarios, which compare each table write against a queue of expected writes built from the descriptors.

// File: rtl/lut_refill_engine.sv
module lut_refill_engine #(
  parameter int LUT_W = 32,
  parameter int LUT_H = 32,
  parameter int NENG  = 4,
  parameter int ENG   = 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                reg_we,
  input  logic [1:0]                          reg_addr,
  input  logic [31:0]                         reg_wdata,
  output logic [31:0]                         reg_rdata,
  output logic                                mem_req,
  output logic [31:0]                         mem_addr,
  input  logic                                mem_rvalid,
  input  logic [31:0]                         mem_rdata,
  output logic                                lut_we,
  output logic [3:0]                          lut_sel,
  output logic [$clog2(LUT_W*LUT_H)-1:0]      lut_idx,
  output logic [31:0]                         lut_data,
  output logic                                irq
);
  localparam int IDXW   = $clog2(LUT_W*LUT_H);
  localparam int IRQW   = 8*NENG;
  localparam int DONE_B = 8*ENG;
  localparam int ERR_B  = 8*ENG + 1;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA} st_t;

  st_t             st;
  logic [1:0]      widx;
  logic            pend, err;
  logic [31:0]     desc, rect, dptr, nxt;
  logic [7:0]      ctl, cx, cy;
  logic [IRQW-1:0] irq_st;

  wire [7:0] x0 = rect[7:0];
  wire [7:0] x1 = rect[15:8];
  wire [7:0] y0 = rect[23:16];
  wire [7:0] y1 = rect[31:24];

  wire take     = mem_rvalid && pend;
  wire ready    = (st == S_IDLE) && !pend;
  wire start_wr = reg_we && (reg_addr == 2'd0);
  wire bad_hdr  = (x1 < x0) || (y1 < y0) || (dptr[3:0] != 4'd0) || (mem_rdata[3:0] != 4'd0);
  wire last_ent = (cx == x1) && (cy == y1);
  wire [31:0] idx_full = 32'(cy) * 32'(LUT_W) + 32'(cx);

  assign mem_req  = (st != S_IDLE) && !pend;
  assign mem_addr = (st == S_HDR) ? desc + {28'd0, widx, 2'b00} : dptr;
  assign lut_we   = (st == S_DATA) && take;
  assign lut_sel  = ctl[7:4];
  assign lut_idx  = idx_full[IDXW-1:0];
  assign lut_data = mem_rdata;
  assign irq      = |irq_st;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = desc;
      2'd1:    reg_rdata = {30'd0, err, ready};
      2'd2:    reg_rdata = 32'(irq_st);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; widx <= '0; pend <= 1'b0; err <= 1'b0;
      desc <= '0; rect <= '0; dptr <= '0; nxt <= '0; ctl <= '0;
      cx <= '0; cy <= '0; irq_st <= '0;
    end else begin
      if (mem_req) pend <= 1'b1;
      else if (take) pend <= 1'b0;

      if (reg_we && reg_addr == 2'd2) irq_st <= irq_st & ~reg_wdata[IRQW-1:0];

      if (take) begin
        case (st)
          S_HDR: begin
            case (widx)
              2'd0:    rect <= mem_rdata;
              2'd1:    ctl  <= mem_rdata[7:0];
              2'd2:    dptr <= mem_rdata;
              default: ;
            endcase
            widx <= widx + 2'd1;
            if (widx == 2'd3) begin
              nxt <= mem_rdata;
              if (bad_hdr) begin
                err <= 1'b1; irq_st[ERR_B] <= 1'b1; st <= S_IDLE;
              end else if (ctl[0]) begin
                st <= S_DATA; cx <= x0; cy <= y0;
              end else if (mem_rdata == 32'd0) begin
                irq_st[DONE_B] <= 1'b1; st <= S_IDLE;
              end else begin
                desc <= mem_rdata;
              end
            end
          end
          S_DATA: begin
            dptr <= dptr + 32'd4;
            if (last_ent) begin
              if (nxt == 32'd0) begin
                irq_st[DONE_B] <= 1'b1; st <= S_IDLE;
              end else begin
                desc <= nxt; st <= S_HDR; widx <= 2'd0;
              end
            end else if (cx == x1) begin
              cx <= x0; cy <= cy + 8'd1;
            end else begin
              cx <= cx + 8'd1;
            end
          end
          default: ;
        endcase
      end

      if (start_wr) begin
        if (reg_wdata == 32'd0) begin
          st <= S_IDLE;
        end else if (ready) begin
          if (reg_wdata[3:0] != 4'd0) begin
            err <= 1'b1; irq_st[ERR_B] <= 1'b1;
          end else begin
            desc <= reg_wdata; err <= 1'b0; st <= S_HDR; widx <= 2'd0;
          end
        end
      end
    end
  end

  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  p_word_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  p_write_in_rect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lut_we |-> (cx >= x0 && cx <= x1 && cy >= y0 && cy <= y1));
  p_cancel_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0 && reg_wdata == 32'd0) |=> (!mem_req && !lut_we));
  p_start_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(start_wr && reg_wdata != 32'd0));
  p_fault_flagged_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> irq_st[ERR_B]);
endmodule

// File: tb/lut_refill_engine_bench.sv
module lut_refill_engine_bench;
  localparam int CLK_NS = 10;
  localparam int LW     = 32;
  localparam int DONE_B = 8;
  localparam int ERR_B  = 9;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        lut_we, irq;
  logic [3:0]  lut_sel;
  logic [9:0]  lut_idx;
  logic [31:0] lut_data;

  lut_refill_engine u_lut_refill_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .lut_we(lut_we), .lut_sel(lut_sel), .lut_idx(lut_idx),
    .lut_data(lut_data), .irq(irq));

  always #(CLK_NS/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done_flag = 1'b0;

  logic [31:0] mem [int unsigned];
  function automatic logic [31:0] rdm(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'h5A5A_0000;
  endfunction

  int lat = 1, lat_cnt = 0;
  logic [31:0] q_addr = '0;
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (lat_cnt > 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rdm(q_addr);
      end
    end else if (mem_req) begin
      q_addr  <= mem_addr;
      lat_cnt <= lat;
    end
  end

  typedef struct packed {logic [9:0] idx; logic [3:0] sel; logic [31:0] d;} exp_t;
  exp_t exq[$];

  always @(negedge clk) begin : monitor
    exp_t e;
    if (rst_n) begin
      if (lut_we) begin
        n_cmp++;
        if (exq.size() == 0) begin
          n_bad++;
          $display("FAIL R3: unexpected table write idx=%0d data=%h, expected none", lut_idx, lut_data);
        end else begin
          e = exq.pop_front();
          if (lut_idx !== e.idx || lut_sel !== e.sel || lut_data !== e.d) begin
            n_bad++;
            $display("FAIL R3: write idx=%0d sel=%0d data=%h, expected idx=%0d sel=%0d data=%h",
                     lut_idx, lut_sel, lut_data, e.idx, e.sel, e.d);
          end
        end
      end
      if (mem_req) begin
        n_cmp++;
        if (lat_cnt != 0 || mem_addr[1:0] != 2'b00) begin
          n_bad++;
          $display("FAIL R11: request addr=%h with %0d cycles outstanding, expected aligned and none", mem_addr, lat_cnt);
        end
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_ready(input string r);
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(2'd1, s);
      if (s[0]) return;
    end
    chk(r, 32'd0, 32'd1);
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [7:0] x0, y0, x1, y1,
                          input logic st, input logic [3:0] sel, input logic [31:0] dp, nx);
    mem[a]      = {y1, y0, x1, x0};
    mem[a + 4]  = {24'd0, sel, 3'd0, st};
    mem[a + 8]  = dp;
    mem[a + 12] = nx;
  endtask

  task automatic push_rect(input int x0, y0, x1, y1, input logic [3:0] sel, input logic [31:0] dp);
    int k = 0;
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) begin
        exq.push_back({10'(y*LW + x), sel, rdm(dp + 32'(4*k))});
        k++;
      end
  endtask

  initial begin : watchdog
    #(CLK_NS*200000);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(2'd1, v); chk("R1 status", v, 32'd1);
    rd(2'd2, v); chk("R1 irq status", v, 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);

    put_desc(32'h100, 8'd2, 8'd1, 8'd4, 8'd2, 1'b1, 4'd5, 32'h1000, 32'd0);
    push_rect(2, 1, 4, 2, 4'd5, 32'h1000);
    wr(2'd0, 32'h100);
    chk("R2 first header addr", mem_addr, 32'h100);
    chk("R2 request issued", 32'(mem_req), 32'd1);
    rd(2'd1, v); chk("R2 busy not ready", 32'(v[0]), 32'd0);
    wait_ready("R4 completion");
    chk("R3 all writes seen", 32'(exq.size()), 32'd0);
    rd(2'd2, v); chk("R4 done bit only", v, 32'd1 << DONE_B);
    chk("R10 irq high", 32'(irq), 32'd1);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R10 cleared", v, 32'd0);
    chk("R10 irq low", 32'(irq), 32'd0);

    lat = 3;
    put_desc(32'h140, 8'd0, 8'd0, 8'd1, 8'd0, 1'b1, 4'd2, 32'h1100, 32'h180);
    put_desc(32'h180, 8'd0, 8'd0, 8'd3, 8'd3, 1'b0, 4'd7, 32'h1200, 32'h1C0);
    put_desc(32'h1C0, 8'd31, 8'd31, 8'd31, 8'd31, 1'b1, 4'hF, 32'h1300, 32'd0);
    push_rect(0, 0, 1, 0, 4'd2, 32'h1100);
    push_rect(31, 31, 31, 31, 4'hF, 32'h1300);
    wr(2'd0, 32'h140);
    wait_ready("R4 chain completion");
    chk("R5 skipped descriptor, R3 count", 32'(exq.size()), 32'd0);
    rd(2'd0, v); chk("R4 last descriptor", v, 32'h1C0);
    rd(2'd2, v); chk("R4 chain done bit", v, 32'd1 << DONE_B);
    wr(2'd2, 32'hFFFF_FFFF);
    lat = 1;

    wr(2'd0, 32'h104);
    rd(2'd1, v); chk("R6 misaligned start status", v, 32'd3);
    rd(2'd2, v); chk("R6 error bit", v, 32'd1 << ERR_B);
    wr(2'd2, 32'hFFFF_FFFF);

    put_desc(32'h200, 8'd5, 8'd0, 8'd3, 8'd0, 1'b1, 4'd1, 32'h1400, 32'd0);
    wr(2'd0, 32'h200);
    wait_ready("R7 inverted end");
    rd(2'd1, v); chk("R7 inverted rect status", v, 32'd3);
    rd(2'd2, v); chk("R7 error bit", v, 32'd1 << ERR_B);
    wr(2'd2, 32'hFFFF_FFFF);

    put_desc(32'h240, 8'd4, 8'd4, 8'd4, 8'd4, 1'b1, 4'd3, 32'h1500, 32'd0);
    push_rect(4, 4, 4, 4, 4'd3, 32'h1500);
    wr(2'd0, 32'h240);
    wait_ready("R6 recovery");
    rd(2'd1, v); chk("R6 start clears ERR", v, 32'd1);
    chk("R3 recovery write", 32'(exq.size()), 32'd0);
    wr(2'd2, 32'hFFFF_FFFF);

    put_desc(32'h280, 8'd0, 8'd0, 8'd1, 8'd1, 1'b1, 4'd3, 32'h1604, 32'd0);
    wr(2'd0, 32'h280);
    wait_ready("R6 data ptr end");
    rd(2'd1, v); chk("R6 misaligned data ptr", v, 32'd3);
    wr(2'd2, 32'hFFFF_FFFF);

    put_desc(32'h2C0, 8'd0, 8'd0, 8'd1, 8'd1, 1'b1, 4'd3, 32'h1700, 32'h308);
    wr(2'd0, 32'h2C0);
    wait_ready("R6 next ptr end");
    rd(2'd1, v); chk("R6 misaligned next ptr", v, 32'd3);
    wr(2'd2, 32'hFFFF_FFFF);

    put_desc(32'h400, 8'd0, 8'd0, 8'd7, 8'd7, 1'b1, 4'd6, 32'h2000, 32'd0);
    push_rect(0, 0, 7, 7, 4'd6, 32'h2000);
    wr(2'd0, 32'h400);
    repeat (60) @(negedge clk);
    wr(2'd0, 32'd0);
    exq.delete();
    repeat (20) @(negedge clk);
    rd(2'd1, v); chk("R8 ready after cancel", v, 32'd1);
    rd(2'd2, v); chk("R8 no completion", v, 32'd0);
    chk("R8 irq low", 32'(irq), 32'd0);

    put_desc(32'h500, 8'd0, 8'd0, 8'd1, 8'd1, 1'b1, 4'd3, 32'h3000, 32'd0);
    push_rect(0, 0, 1, 1, 4'd3, 32'h3000);
    wr(2'd0, 32'h500);
    repeat (5) @(negedge clk);
    wr(2'd0, 32'h600);
    wait_ready("R9 completion");
    chk("R9 original writes only", 32'(exq.size()), 32'd0);
    rd(2'd0, v); chk("R9 descriptor unchanged", v, 32'h500);
    rd(2'd2, v); chk("R9 done bit", v, 32'd1 << DONE_B);

    repeat (10) @(negedge clk);
    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule